// File: doc/BRIEF.md
# PWM Timer with Buffered Period and Duty Registers

This block is a single-channel up-counting pulse-width timer. A free-running counter advances by one on every clock in which the timer is enabled. It returns to zero when it exactly equals the active period value. The output pin is high while the count is below the active duty (compare) value. Software sets the period, the duty value and a two-bit buffering control through a small register write port. It also sees the live count on a readback port.

Each of the two timing registers can work in one of two ways, selected by its own bit in the control register. In direct mode a write changes the active value in the next cycle. In buffered mode a write lands in a holding register, and the holding value becomes active only at the next update event. An update event happens when the counter resets at the period match, or when it rolls over from its all-ones value to zero. The period check is strict equality. If a direct write sets the period below the present count, the counter keeps climbing until it rolls over at 2^CNT_W, and the output stays low for that whole run. Buffered mode avoids this.

The write port is a plain control interface. The block accepts a write on every cycle in which `wr_en` is high, and there is no back-pressure: no ready signal exists and no write is ever stalled or dropped. Address map: 0 = period, 1 = duty, 2 = control (bit 0 buffers the period, bit 1 buffers the duty). Writes to address 3 are discarded.

Top module: `pwm_preload_timer`

## Requirements
- R1: After reset, `cnt_o` increases by exactly one on each clock with `en` high, and it holds its value on each clock with `en` low.
- R2: When `en` is high and `cnt_o` equals the active period, the next count is 0.
- R3: When a direct write sets the period below the present count, the counter keeps counting up to 2^CNT_W-1 and then to 0, after which the new period governs.
- R4: An update event occurs on an enabled cycle in which the count equals the active period or equals 2^CNT_W-1. Buffered values are transferred only on these cycles.
- R5: With control bit 0 clear, a write to address 0 becomes the active period on the next cycle.
- R6: With control bit 0 set and `en` high, a write to address 0 is held. It becomes the active period only after the next update event.
- R7: Control bit 1 selects direct or buffered behaviour for the duty register at address 1, under the same rules as R5 and R6.
- R8: While `en` is low, writes to the period and duty registers become active at once, whatever the control bits are.
- R9: `pwm_o` is 1 exactly when `cnt_o` is below the active duty value.
- R10: When a buffered write arrives in the same cycle as an update event, the earlier held value becomes active, and the newly written value waits for the following update event.
- R11: Reset sets the following values: count 0, active and held period all ones, active and held duty 0, control 0, and `pwm_o` low.
- R12: A write to address 3 changes no register. Writes are taken on every cycle in which `wr_en` is high, without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Counter run enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 period, 1 duty, 2 control) |
| wr_data | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current count |
| pwm_o | output | 1 | Pulse-width output |

## Verification
A buffered register write and an update event can fall on the same clock. The bench provokes this by running until its model count equals the model period, and then issuing the write on exactly that cycle. Correctness is judged by the count sequence that follows: the previously held period must take effect first, and the new one must appear only one period later. A second overlap is a direct period write that shrinks the period below the running count. The bench judges this by following the counter through the full roll-over, with the output held low throughout, and then checking that the new period is obeyed.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  typedef enum logic [1:0] {
    ADR_PERIOD = 2'd0,
    ADR_DUTY   = 2'd1,
    ADR_CTRL   = 2'd2,
    ADR_NONE   = 2'd3
  } reg_addr_e;

  localparam int CTRL_W        = 2;
  localparam int CTRL_PER_BUF  = 0;
  localparam int CTRL_DUTY_BUF = 1;
endpackage

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             upd
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic hit_period;
  logic hit_top;

  assign hit_period = (cnt == period);
  assign hit_top    = (cnt == TOP);
  assign upd        = run & (hit_period | hit_top);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (upd)  cnt <= '0;
    else if (run)  cnt <= cnt + 1'b1;
  end

  // R2
  period_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == period) |=> (cnt == '0));

  // R3
  overrun_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt > period && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> $stable(cnt));
endmodule

// File: rtl/pwm_tmr_buffered_reg.sv
module pwm_tmr_buffered_reg #(
  parameter int           W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         buf_en,
  input  logic         run,
  input  logic         upd,
  output logic [W-1:0] act
);
  logic [W-1:0] held;
  logic         defer;

  assign defer = buf_en & run;

  always_ff @(posedge clk) begin
    if (!rst_n)  held <= RST;
    else if (wr) held <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                act <= RST;
    else if (wr && !defer)     act <= wdata;
    else if (upd && buf_en)    act <= held;
  end

  // R5
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !defer) |=> (act == $past(wdata)));

  // R6
  preload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (defer && !upd) |=> $stable(act));

  // R10
  transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (defer && upd) |=> (act == $past(held)));
endmodule

// File: rtl/pwm_tmr_compare.sv
module pwm_tmr_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm
);
  assign pwm = (cnt < duty);

  // R9
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |-> !pwm);
endmodule

// File: rtl/pwm_preload_timer.sv
module pwm_preload_timer
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] PER_RST = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] DUTY_RST = '0;

  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  per_act;
  logic [CNT_W-1:0]  duty_act;
  logic              upd;
  logic              wr_per, wr_duty, wr_ctrl;

  assign wr_per  = wr_en && (reg_addr_e'(wr_addr) == ADR_PERIOD);
  assign wr_duty = wr_en && (reg_addr_e'(wr_addr) == ADR_DUTY);
  assign wr_ctrl = wr_en && (reg_addr_e'(wr_addr) == ADR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl <= '0;
    else if (wr_ctrl) ctrl <= wr_data[CTRL_W-1:0];
  end

  pwm_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(en), .period(per_act),
    .cnt(cnt_o), .upd(upd)
  );

  pwm_tmr_buffered_reg #(.W(CNT_W), .RST(PER_RST)) u_per (
    .clk(clk), .rst_n(rst_n), .wr(wr_per), .wdata(wr_data),
    .buf_en(ctrl[CTRL_PER_BUF]), .run(en), .upd(upd), .act(per_act)
  );

  pwm_tmr_buffered_reg #(.W(CNT_W), .RST(DUTY_RST)) u_duty (
    .clk(clk), .rst_n(rst_n), .wr(wr_duty), .wdata(wr_data),
    .buf_en(ctrl[CTRL_DUTY_BUF]), .run(en), .upd(upd), .act(duty_act)
  );

  pwm_tmr_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_o), .duty(duty_act), .pwm(pwm_o)
  );

  // R8
  idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && wr_per) |=> (per_act == $past(wr_data)));

  // R12
  spare_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> $stable(ctrl));
endmodule

// File: tb/pwm_preload_timer_test.sv
module pwm_preload_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam int WDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt_o;
  logic pwm_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [W-1:0] m_cnt, m_per, m_per_h, m_duty, m_duty_h;
  logic [1:0] m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_preload_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt_o), .pwm_o(pwm_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WDOG) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pick(input logic bufd, input logic run, input logic upd,
      input logic wr, input logic [W-1:0] d, input logic [W-1:0] act, input logic [W-1:0] held);
    if (wr && !(bufd && run)) return d;
    if (upd && bufd) return held;
    return act;
  endfunction

  // one clock: drive at negedge, model next state, then sample at next negedge
  task automatic cyc(input string tag, input logic e, input logic w,
                     input logic [1:0] a, input logic [W-1:0] d);
    logic upd, wp, wd;
    logic [W-1:0] n_cnt, n_per, n_duty;
    en = e; wr_en = w; wr_addr = a; wr_data = d;
    upd = e && (m_cnt == m_per || m_cnt == TOP);
    wp = w && a == 2'd0;
    wd = w && a == 2'd1;
    n_cnt = upd ? '0 : (e ? m_cnt + 1'b1 : m_cnt);
    n_per = pick(m_ctrl[0], e, upd, wp, d, m_per, m_per_h);
    n_duty = pick(m_ctrl[1], e, upd, wd, d, m_duty, m_duty_h);
    @(posedge clk);
    @(negedge clk);
    if (wp) m_per_h = d;
    if (wd) m_duty_h = d;
    if (w && a == 2'd2) m_ctrl = d[1:0];
    m_cnt = n_cnt; m_per = n_per; m_duty = n_duty;
    chk({tag, " cnt"}, cnt_o, m_cnt);
    chk({tag, " pwm R9"}, W'(pwm_o), W'(m_cnt < m_duty));
  endtask

  task automatic run_n(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b1, 1'b0, 2'd0, '0);
  endtask

  initial begin
    m_cnt = '0; m_per = TOP; m_per_h = TOP; m_duty = '0; m_duty_h = '0; m_ctrl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset cnt", cnt_o, '0);
    chk("R11 reset pwm", W'(pwm_o), '0);

    // R1: plain count then hold
    run_n("R1 count", 20);
    chk("R1 count after 20", cnt_o, W'(20));
    for (int i = 0; i < 5; i++) cyc("R1 hold", 1'b0, 1'b0, 2'd0, '0);
    chk("R1 held", cnt_o, W'(20));

    // R5 / R7 / R9 direct writes
    cyc("R5 per", 1'b1, 1'b1, 2'd0, W'(40));
    cyc("R7 duty", 1'b1, 1'b1, 2'd1, W'(15));
    run_n("R2 R9 period", 60);

    // R3 overrun: shrink period below count
    cyc("R3 per", 1'b1, 1'b1, 2'd0, W'(300));
    while (m_cnt != W'(250)) run_n("R3 climb", 1);
    cyc("R3 shrink", 1'b1, 1'b1, 2'd0, W'(30));
    while (m_cnt != TOP) run_n("R3 run on", 1);
    chk("R3 reached top", cnt_o, TOP);
    chk("R3 low while over", W'(pwm_o), '0);
    run_n("R3 wrap", 1);
    chk("R3 wrapped", cnt_o, '0);
    run_n("R3 new period", 40);

    // R6 / R4 buffered period
    cyc("R6 ctrl", 1'b1, 1'b1, 2'd2, W'(1));
    while (m_cnt != W'(2)) run_n("R6 align", 1);
    cyc("R6 write", 1'b1, 1'b1, 2'd0, W'(10));
    run_n("R6 old period", 25);
    chk("R6 period 30 kept until update", cnt_o, m_cnt);
    run_n("R4 new period", 30);

    // R10 write on update cycle
    while (m_cnt != m_per) run_n("R10 align", 1);
    cyc("R10 collide", 1'b1, 1'b1, 2'd0, W'(50));
    run_n("R10 after", 80);

    // R7 buffered duty
    cyc("R7 ctrl", 1'b1, 1'b1, 2'd2, W'(3));
    cyc("R7 duty", 1'b1, 1'b1, 2'd1, W'(3));
    run_n("R7 after", 120);

    // R8 idle writes land at once
    cyc("R8 stop", 1'b0, 1'b0, 2'd0, '0);
    cyc("R8 per", 1'b0, 1'b1, 2'd0, W'(20));
    cyc("R8 duty", 1'b0, 1'b1, 2'd1, W'(9));
    run_n("R8 run", 50);

    // R12 spare address
    cyc("R12 spare", 1'b1, 1'b1, 2'd3, '0);
    run_n("R12 after", 30);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic w;
      logic [1:0] a;
      logic [W-1:0] d;
      w = ($urandom % 8) == 0;
      a = 2'($urandom % 4);
      d = (a == 2'd2) ? W'($urandom % 4) : W'(($urandom % 120) + 5);
      cyc("R1 R4 R10 random", ($urandom % 16) != 0, w, a, d);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    process p;
    p = process::self();
    void'($urandom(32'd1234));
  end
endmodule